// File: doc/BRIEF.md
# Host Command Stream Parser

This block sits at the front of a multimedia engine controller. It takes a stream of 32-bit command words from a host and turns it into register writes. Each write carries a target class, a method offset and a 32-bit data value. A word that arrives while no payload is pending is a header. Its top four bits pick a submission mode, bits 27..16 give a method offset, and bits 15..0 carry a mode-specific value.

There are four addressing modes for payload words:
- A counted mode that steps the offset after each word.
- A counted mode that keeps the offset fixed.
- A sparse mode that walks a 16-bit mask from its lowest set bit upward.
- An inline mode that writes a 12-bit value at once and takes no payload.

A class-select header changes the target class. It can also carry a 6-bit mask of writes that follow it. Words enter on a valid/ready port and writes leave on a second valid/ready port. The input stalls while a write is waiting to be taken.

Top module: `cmd_stream_parser`

## Requirements
- R1: After synchronous reset, wr_valid and err_pulse are 0 and in_ready is 1. The current class, offset, pending mask and pending count are all zero, so an inline write issued straight after reset carries class 0.
- R2: A header with mode 4 (inline) emits one write. The write goes to the current class at the offset in bits 27..16, with data equal to bits 11..0 zero-extended. It consumes no payload, so the next word is decoded as a header.
- R3: A header with mode 1 loads a 16-bit count from bits 15..0 and a base offset from bits 27..16. The next count words are written to the base offset, base+1, base+2 and so on. A count of zero consumes no payload.
- R4: A header with mode 2 loads the count and base offset in the same way, but every payload word is written to the base offset.
- R5: A header with mode 3 loads a 16-bit mask from bits 15..0 and a base offset from bits 27..16. Each payload word goes to the base plus the index of the lowest set mask bit, and that bit is then cleared. A zero mask consumes no payload.
- R6: A header with mode 0 (class select) sets the class from bits 15..6 and the base offset from bits 27..16, and loads a 6-bit mask from bits 5..0. The mask is walked as in R5, and all later writes carry the new class. The header itself emits no write.
- R7: A word is decoded as a header only when no mask bits and no count remain. A payload word whose top bits look like a header is written as plain data.
- R8: A header whose mode is 5 to 15 emits no write and leaves the class, offset, mask and count unchanged. It raises err_pulse for exactly one cycle, in the cycle after it is accepted.
- R9: in_ready is high exactly when no write is pending or the pending write is being taken. While wr_valid is high and wr_ready is low, wr_class, wr_offset and wr_data hold steady.
- R10: Offset arithmetic is 12 bits wide and wraps. Both the incrementing step and the base-plus-bit-index sum wrap from 0xFFF to 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command word valid |
| in_ready | output | 1 | Command word accepted this cycle when valid |
| in_word | input | 32 | Command word |
| wr_valid | output | 1 | Register write valid |
| wr_ready | input | 1 | Consumer takes the write |
| wr_class | output | 10 | Target class of the write |
| wr_offset | output | 12 | Method offset of the write |
| wr_data | output | 32 | Write data |
| err_pulse | output | 1 | One-cycle flag for an unknown mode |

## Verification
The assertions check the output handshake on every cycle: writes stay stable while stalled, and the input is blocked behind a stalled write. They also check the quiet state after reset, that an unknown mode flags without writing, and that a count, mask or class-select header never produces a write by itself. The bench scenarios are needed for the values themselves. These are the offset order of the mask walk, increment versus fixed addressing, offset wrap, class persistence across headers, and treating header-shaped payload words as data.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;

    localparam int CMD_W      = 32;
    localparam int VAL_W      = 16;
    localparam int OFS_W      = 12;
    localparam int MODE_W     = 4;
    localparam int CLS_W      = 10;
    localparam int SEL_MASK_W = 6;
    localparam int IMM_W      = 12;

    localparam int OFS_LSB  = VAL_W;
    localparam int MODE_LSB = OFS_LSB + OFS_W;
    localparam int CLS_LSB  = SEL_MASK_W;
    localparam int IDX_W    = $clog2(VAL_W);

    typedef enum logic [MODE_W-1:0] {
        MODE_CLASS = 4'd0,
        MODE_INC   = 4'd1,
        MODE_FIX   = 4'd2,
        MODE_MASK  = 4'd3,
        MODE_IMM   = 4'd4
    } mode_e;

    typedef struct packed {
        logic [MODE_W-1:0]     mode;
        logic [OFS_W-1:0]      ofs;
        logic [VAL_W-1:0]      val;
        logic [CLS_W-1:0]      cls;
        logic [SEL_MASK_W-1:0] sel_mask;
    } hdr_t;

    typedef struct packed {
        logic [CLS_W-1:0] cls;
        logic [OFS_W-1:0] ofs;
        logic [VAL_W-1:0] mask;
        logic [VAL_W-1:0] count;
        logic             incr;
    } st_t;

    typedef struct packed {
        logic [CLS_W-1:0] cls;
        logic [OFS_W-1:0] ofs;
        logic [CMD_W-1:0] data;
    } wr_t;

    function automatic hdr_t split_header(input logic [CMD_W-1:0] w);
        hdr_t h;
        h.mode     = w[MODE_LSB +: MODE_W];
        h.ofs      = w[OFS_LSB +: OFS_W];
        h.val      = w[0 +: VAL_W];
        h.cls      = w[CLS_LSB +: CLS_W];
        h.sel_mask = w[0 +: SEL_MASK_W];
        return h;
    endfunction

endpackage

// File: rtl/cmdp_hdr_decode.sv
module cmdp_hdr_decode
    import cmdp_pkg::*;
(
    input  logic [CMD_W-1:0] word,
    output hdr_t             hdr
);
    always_comb begin
        hdr = split_header(word);
    end
endmodule

// File: rtl/cmdp_lowbit.sv
module cmdp_lowbit #(
    parameter int N = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic [N-1:0]  onehot,
    output logic [IW-1:0] idx
);
    logic [N:0] below_clear;
    assign below_clear[0] = 1'b1;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign onehot[i]        = vec[i] & below_clear[i];
        assign below_clear[i+1] = below_clear[i] & ~vec[i];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot[i]) idx = idx | IW'(i);
        end
    end
endmodule

// File: rtl/cmdp_step.sv
module cmdp_step
    import cmdp_pkg::*;
(
    input  logic             take,
    input  logic [CMD_W-1:0] word,
    input  hdr_t             hdr,
    input  st_t              cur,
    input  logic [VAL_W-1:0] low_onehot,
    input  logic [IDX_W-1:0] low_idx,
    output st_t              nxt,
    output logic             emit,
    output wr_t              wr,
    output logic             bad
);
    always_comb begin
        nxt  = cur;
        emit = 1'b0;
        wr   = '0;
        bad  = 1'b0;
        if (take) begin
            if (cur.mask != '0) begin
                emit     = 1'b1;
                wr.cls   = cur.cls;
                wr.ofs   = cur.ofs + OFS_W'(low_idx);
                wr.data  = word;
                nxt.mask = cur.mask & ~low_onehot;
            end else if (cur.count != '0) begin
                emit      = 1'b1;
                wr.cls    = cur.cls;
                wr.ofs    = cur.ofs;
                wr.data   = word;
                nxt.count = cur.count - VAL_W'(1);
                if (cur.incr) nxt.ofs = cur.ofs + OFS_W'(1);
            end else begin
                case (hdr.mode)
                    MODE_CLASS: begin
                        nxt.mask = VAL_W'(hdr.sel_mask);
                        nxt.ofs  = hdr.ofs;
                        nxt.cls  = hdr.cls;
                    end
                    MODE_INC, MODE_FIX: begin
                        nxt.count = hdr.val;
                        nxt.ofs   = hdr.ofs;
                        nxt.incr  = (hdr.mode == MODE_INC);
                    end
                    MODE_MASK: begin
                        nxt.mask = hdr.val;
                        nxt.ofs  = hdr.ofs;
                    end
                    MODE_IMM: begin
                        nxt.ofs = hdr.ofs;
                        emit    = 1'b1;
                        wr.cls  = cur.cls;
                        wr.ofs  = hdr.ofs;
                        wr.data = CMD_W'(hdr.val[IMM_W-1:0]);
                    end
                    default: bad = 1'b1;
                endcase
            end
        end
    end
endmodule

// File: rtl/cmd_stream_parser.sv
module cmd_stream_parser
    import cmdp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [CMD_W-1:0] in_word,
    output logic             wr_valid,
    input  logic             wr_ready,
    output logic [CLS_W-1:0] wr_class,
    output logic [OFS_W-1:0] wr_offset,
    output logic [CMD_W-1:0] wr_data,
    output logic             err_pulse
);
    st_t              st_q, st_d;
    wr_t              wr_q, wr_d;
    hdr_t             hdr;
    logic             wr_valid_q, err_q;
    logic             take, emit, bad;
    logic [VAL_W-1:0] low_onehot;
    logic [IDX_W-1:0] low_idx;

    assign in_ready = !wr_valid_q || wr_ready;
    assign take     = in_valid && in_ready;

    cmdp_hdr_decode u_dec (
        .word (in_word),
        .hdr  (hdr)
    );

    cmdp_lowbit #(.N(VAL_W)) u_low (
        .vec    (st_q.mask),
        .onehot (low_onehot),
        .idx    (low_idx)
    );

    cmdp_step u_step (
        .take       (take),
        .word       (in_word),
        .hdr        (hdr),
        .cur        (st_q),
        .low_onehot (low_onehot),
        .low_idx    (low_idx),
        .nxt        (st_d),
        .emit       (emit),
        .wr         (wr_d),
        .bad        (bad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            wr_q       <= '0;
            wr_valid_q <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            st_q  <= st_d;
            err_q <= bad;
            if (emit) begin
                wr_valid_q <= 1'b1;
                wr_q       <= wr_d;
            end else if (wr_ready) begin
                wr_valid_q <= 1'b0;
            end
        end
    end

    assign wr_valid  = wr_valid_q;
    assign wr_class  = wr_q.cls;
    assign wr_offset = wr_q.ofs;
    assign wr_data   = wr_q.data;
    assign err_pulse = err_q;
endmodule

// File: rtl/cmdp_checker.sv
module cmdp_checker
    import cmdp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic [CMD_W-1:0] in_word,
    input logic             wr_valid,
    input logic             wr_ready,
    input logic [CLS_W-1:0] wr_class,
    input logic [OFS_W-1:0] wr_offset,
    input logic [CMD_W-1:0] wr_data,
    input logic             err_pulse,
    input logic [VAL_W-1:0] pend_mask,
    input logic [VAL_W-1:0] pend_count
);
    // R1: quiet outputs on the cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!wr_valid && !err_pulse));

    // R9: stalled write keeps its fields
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_class)
                                     && $stable(wr_offset) && $stable(wr_data)));

    // R9: input blocked behind a stalled write
    a_r9_input_stall: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |-> !in_ready);

    // R8: unknown mode flags without a write
    a_r8_err_no_write: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> !wr_valid);

    // R8: flag only follows an accepted word
    a_r8_err_after_accept: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> $past(in_valid && in_ready));

    // R3, R5, R6: count, mask and class headers emit nothing themselves
    a_r6_hdr_no_write: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && pend_mask == '0 && pend_count == '0
         && in_word[CMD_W-1 -: MODE_W] <= 4'd3) |=> !wr_valid);
endmodule

bind cmd_stream_parser cmdp_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_word    (in_word),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_class   (wr_class),
    .wr_offset  (wr_offset),
    .wr_data    (wr_data),
    .err_pulse  (err_pulse),
    .pend_mask  (st_q.mask),
    .pend_count (st_q.count)
);

// File: tb/cmd_stream_parser_tb_top.sv
module cmd_stream_parser_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        wr_valid;
    logic        wr_ready = 1'b1;
    logic [9:0]  wr_class;
    logic [11:0] wr_offset;
    logic [31:0] wr_data;
    logic        err_pulse;

    int n_chk = 0;
    int n_fail = 0;
    int log_n = 0;
    int err_n = 0;
    logic [9:0]  log_cls [64];
    logic [11:0] log_ofs [64];
    logic [31:0] log_dat [64];

    always #5 clk = ~clk;

    cmd_stream_parser dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_class(wr_class), .wr_offset(wr_offset), .wr_data(wr_data),
        .err_pulse(err_pulse)
    );

    always @(negedge clk) begin
        #2;
        if (!rst) begin
            if (wr_valid && wr_ready && log_n < 64) begin
                log_cls[log_n] = wr_class;
                log_ofs[log_n] = wr_offset;
                log_dat[log_n] = wr_data;
                log_n++;
            end
            if (err_pulse) err_n++;
        end
    end

    function automatic logic [31:0] mk(input logic [3:0] mode, input logic [11:0] ofs,
                                       input logic [15:0] val);
        return {mode, ofs, val};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_wr(input int i, input logic [9:0] c, input logic [11:0] o,
                          input logic [31:0] d, input string req);
        logic [53:0] act, exp;
        exp = {c, o, d};
        act = (i < log_n) ? {log_cls[i], log_ofs[i], log_dat[i]} : '1;
        check(act == exp, req, $sformatf("write %0d", i), 64'(act), 64'(exp));
    endtask

    task automatic chk_n(input int n, input string req);
        check(log_n == n, req, "write count", 64'(log_n), 64'(n));
    endtask

    task automatic send(input logic [31:0] w);
        in_valid = 1'b1;
        in_word  = w;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic start();
        settle();
        log_n = 0;
        err_n = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        check(!wr_valid && !err_pulse && in_ready, "R1", "idle after reset",
              {61'd0, wr_valid, err_pulse, in_ready}, 64'd1);
        log_n = 0;
        send(mk(4'd4, 12'h123, 16'hFABC));
        send(mk(4'd4, 12'h7FF, 16'h0001));
        settle();
        chk_n(2, "R2");
        chk_wr(0, 10'h000, 12'h123, 32'h0000_0ABC, "R1");
        chk_wr(1, 10'h000, 12'h7FF, 32'h0000_0001, "R2");
    endtask

    task automatic t_class();
        start();
        send(mk(4'd0, 12'h040, {10'h2A5, 6'b000000}));
        settle();
        chk_n(0, "R6");
        send(mk(4'd4, 12'h005, 16'h0077));
        send(mk(4'd0, 12'h010, {10'h033, 6'b100101}));
        send(32'hAAAA_0001);
        send(32'hBBBB_0002);
        send(32'hCCCC_0003);
        send(mk(4'd4, 12'h006, 16'h0066));
        settle();
        chk_n(5, "R6");
        chk_wr(0, 10'h2A5, 12'h005, 32'h77, "R6");
        chk_wr(1, 10'h033, 12'h010, 32'hAAAA_0001, "R6");
        chk_wr(2, 10'h033, 12'h012, 32'hBBBB_0002, "R6");
        chk_wr(3, 10'h033, 12'h015, 32'hCCCC_0003, "R6");
        chk_wr(4, 10'h033, 12'h006, 32'h66, "R6");
    endtask

    task automatic t_incr();
        start();
        send(mk(4'd1, 12'hFFE, 16'd3));
        send(32'h1111_1111);
        send(32'h4000_0001);
        send(32'h3333_3333);
        send(mk(4'd4, 12'h020, 16'h0ABC));
        settle();
        chk_n(4, "R3");
        chk_wr(0, 10'h033, 12'hFFE, 32'h1111_1111, "R3");
        chk_wr(1, 10'h033, 12'hFFF, 32'h4000_0001, "R7");
        chk_wr(2, 10'h033, 12'h000, 32'h3333_3333, "R10");
        chk_wr(3, 10'h033, 12'h020, 32'hABC, "R7");
    endtask

    task automatic t_fixed();
        start();
        send(mk(4'd2, 12'h200, 16'd3));
        send(32'hD0);
        send(32'hD1);
        send(32'hD2);
        send(mk(4'd1, 12'h300, 16'd0));
        send(mk(4'd4, 12'h301, 16'h0005));
        settle();
        chk_n(4, "R4");
        chk_wr(0, 10'h033, 12'h200, 32'hD0, "R4");
        chk_wr(1, 10'h033, 12'h200, 32'hD1, "R4");
        chk_wr(2, 10'h033, 12'h200, 32'hD2, "R4");
        chk_wr(3, 10'h033, 12'h301, 32'h5, "R3");
    endtask

    task automatic t_mask();
        start();
        send(mk(4'd3, 12'hFF8, 16'h8002));
        send(32'hE1);
        send(32'hE2);
        send(mk(4'd3, 12'h100, 16'h0000));
        send(mk(4'd4, 12'h101, 16'h0009));
        settle();
        chk_n(3, "R5");
        chk_wr(0, 10'h033, 12'hFF9, 32'hE1, "R5");
        chk_wr(1, 10'h033, 12'h007, 32'hE2, "R10");
        chk_wr(2, 10'h033, 12'h101, 32'h9, "R5");
    endtask

    task automatic t_unknown();
        start();
        send(mk(4'd7, 12'h111, 16'h1234));
        settle();
        check(err_n == 1, "R8", "single error pulse", 64'(err_n), 64'd1);
        chk_n(0, "R8");
        send(mk(4'd5, 12'h222, 16'h0001));
        send(mk(4'd15, 12'h333, 16'h0002));
        send(mk(4'd4, 12'h044, 16'h0004));
        settle();
        check(err_n == 3, "R8", "error pulses", 64'(err_n), 64'd3);
        chk_n(1, "R8");
        chk_wr(0, 10'h033, 12'h044, 32'h4, "R8");
    endtask

    task automatic t_backpressure();
        start();
        wr_ready = 1'b0;
        send(mk(4'd4, 12'h0A0, 16'h0011));
        in_valid = 1'b1;
        in_word  = mk(4'd4, 12'h0B0, 16'h0022);
        repeat (4) begin
            @(negedge clk);
            #1;
            check(!in_ready, "R9", "input stalled", {63'd0, in_ready}, 64'd0);
            check(wr_valid && wr_offset == 12'h0A0 && wr_data == 32'h11, "R9",
                  "held write", {51'd0, wr_valid, wr_offset}, {51'd0, 1'b1, 12'h0A0});
        end
        wr_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        settle();
        chk_n(2, "R9");
        chk_wr(0, 10'h033, 12'h0A0, 32'h11, "R9");
        chk_wr(1, 10'h033, 12'h0B0, 32'h22, "R9");
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #1_500_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_class();
        t_incr();
        t_fixed();
        t_mask();
        t_unknown();
        t_backpressure();
        summary();
        $finish;
    end
endmodule